// File: doc/BRIEF.md
# Ordering-stall prefetch issuer

This block sits beside the load and store buffers of a processor core. Each cycle it can receive one descriptor for an access that ordering rules are holding back. A descriptor carries the cache line address and the access kind: load, store, or atomic read-modify-write. The block turns each descriptor into a non-binding prefetch. Loads ask for the line in a shared, read-only state. Stores and atomics ask for exclusive ownership, but only when the system keeps caches coherent by invalidation. When coherence works by updates, store and atomic descriptors are dropped.

Prefetches wait in a small FIFO. The oldest entry is checked against the cache tags through a probe port. If the line is already cached, the entry is discarded. If it is not, the entry is sent to the memory request port, one per cycle at most, as soon as a slot in the outstanding-miss table is free. The table keeps the line and the request type until the response comes back. On the response, the block tells the cache to install the line and frees the slot.

A demand access to a line that is still in flight is merged with the prefetch. The block flags the merge in the same cycle, so no second request goes out, and it signals completion when the prefetch data arrives. A new descriptor whose line is already queued or already in flight is accepted and then discarded.

Top module: `pf_issuer`

## Requirements
- R1: The access kind is encoded as 0 = load, 1 = store, 2 = atomic. A load produces a request with mem_excl_o = 0. A store or atomic produces mem_excl_o = 1.
- R2: The oldest queued prefetch drives probe_line_o and probe_valid_o. If probe_hit_i is 1, that prefetch is removed at the next clock edge and no memory request is made for it.
- R3: A queued prefetch whose probe misses raises mem_valid_o with its line address. It leaves the queue on the edge where mem_ready_i is 1. Prefetches are issued in arrival order, at most one per cycle, and a request held by mem_ready_i = 0 keeps the same line and type.
- R4: A response whose line matches an in-flight prefetch raises fill_valid_o in the same cycle, with that line on fill_line_o and the stored type on fill_excl_o, and frees the table slot. A response for any other line leaves fill_valid_o at 0.
- R5: A demand on dmd_valid_i / dmd_line_i for an in-flight line raises dmd_merge_o in the same cycle. A demand for any other line leaves it at 0. When the response for a merged line arrives, dmd_done_o pulses together with fill_valid_o and dmd_done_line_o carries the line.
- R6: When a demand and the response for the same in-flight line arrive in the same cycle, dmd_merge_o and dmd_done_o are both 1 in that cycle. Afterwards the line is no longer in flight.
- R7: With INVAL_BASED = 0, store and atomic descriptors are accepted and discarded, so they never reach the probe or memory ports. Loads are still prefetched.
- R8: trig_ready_o is 0 while the queue holds FIFO_DEPTH entries. mem_valid_o stays 0 while all MISS_N table slots are busy.
- R9: A descriptor whose line is already queued or already in flight is accepted and dropped, so that line is never requested twice.
- R10: After reset, trig_ready_o = 1 and probe_valid_o, mem_valid_o, fill_valid_o, dmd_merge_o and dmd_done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_valid_i | input | 1 | Descriptor of an access stalled by ordering rules |
| trig_line_i | input | LINE_W | Line address of the stalled access |
| trig_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 atomic |
| trig_ready_o | output | 1 | The queue can take a descriptor |
| probe_valid_o | output | 1 | Tag probe for the oldest queued prefetch |
| probe_line_o | output | LINE_W | Line address being probed |
| probe_hit_i | input | 1 | The probed line is present in the cache |
| mem_valid_o | output | 1 | Prefetch request to memory |
| mem_line_o | output | LINE_W | Line address of the request |
| mem_excl_o | output | 1 | 1 = exclusive request, 0 = shared request |
| mem_ready_i | input | 1 | Memory accepts the request |
| rsp_valid_i | input | 1 | Response from memory |
| rsp_line_i | input | LINE_W | Line address of the response |
| fill_valid_o | output | 1 | Install the returned line in the cache |
| fill_line_o | output | LINE_W | Line address to install |
| fill_excl_o | output | 1 | Install in exclusive state |
| dmd_valid_i | input | 1 | Demand access lookup |
| dmd_line_i | input | LINE_W | Line address of the demand |
| dmd_merge_o | output | 1 | The demand was absorbed by an in-flight prefetch |
| dmd_done_o | output | 1 | A merged demand completes |
| dmd_done_line_o | output | LINE_W | Line address of the completed demand |

## Verification
Two collisions matter most. The first is a demand and the response for the same line arriving in the same cycle. The bench drives both at once and expects dmd_merge_o and dmd_done_o together in that cycle, and then no merge for a repeat demand to that line. The second is a descriptor arriving on the very edge where its line leaves the queue for the miss table. The bench provokes it at the issuing cycle and expects the queue to be empty afterwards, with no second request for that line.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_ATOMIC = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              push_excl_i,
  input  logic              pop_i,
  output logic [LINE_W-1:0] head_line_o,
  output logic              head_excl_o,
  output logic              empty_o,
  output logic              full_o,
  input  logic [LINE_W-1:0] qry_line_i,
  output logic              qry_hit_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LINE_W-1:0] line_q [DEPTH];
  logic              excl_q [DEPTH];
  logic [PW-1:0]     rd_q, wr_q;
  logic [PW:0]       cnt_q;

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == (PW+1)'(DEPTH));
  assign head_line_o = line_q[rd_q];
  assign head_excl_o = excl_q[rd_q];

  // compare the query against every occupied slot
  always_comb begin
    logic [PW-1:0] rel;
    qry_hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      rel = PW'(i) - rd_q;
      if (({1'b0, rel} < cnt_q) && (line_q[i] == qry_line_i)) qry_hit_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        excl_q[i] <= 1'b0;
      end
    end else begin
      if (push_i) begin
        line_q[wr_q] <= push_line_i;
        excl_q[wr_q] <= push_excl_i;
        wr_q         <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
      if (pop_i) rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  // R3
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R8
  push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/pf_miss_table.sv
module pf_miss_table #(
  parameter int LINE_W  = 26,
  parameter int ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              alloc_excl_i,
  output logic              full_o,
  input  logic [LINE_W-1:0] trig_line_i,
  output logic              trig_hit_o,
  input  logic              dmd_valid_i,
  input  logic [LINE_W-1:0] dmd_line_i,
  output logic              dmd_hit_o,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  output logic              rsp_hit_o,
  output logic              rsp_excl_o,
  output logic              rsp_merged_o
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, excl_q, mrg_q;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ENTRIES-1:0] trig_m, dmd_m, rsp_m, alloc_m;
  logic [IW-1:0]      free_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign trig_m[g]  = vld_q[g] && (line_q[g] == trig_line_i);
    assign dmd_m[g]   = vld_q[g] && dmd_valid_i && (line_q[g] == dmd_line_i);
    assign rsp_m[g]   = vld_q[g] && rsp_valid_i && (line_q[g] == rsp_line_i);
    assign alloc_m[g] = vld_q[g] && (line_q[g] == alloc_line_i);
  end

  assign full_o     = &vld_q;
  assign trig_hit_o = |trig_m;
  assign dmd_hit_o  = |dmd_m;
  assign rsp_hit_o  = |rsp_m;
  assign rsp_excl_o   = |(rsp_m & excl_q);
  assign rsp_merged_o = |(rsp_m & mrg_q);

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) if (!vld_q[i]) free_idx = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      excl_q <= '0;
      mrg_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) line_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rsp_m[i])      vld_q[i] <= 1'b0;
        else if (dmd_m[i]) mrg_q[i] <= 1'b1;
      end
      if (alloc_i) begin
        vld_q[free_idx]  <= 1'b1;
        line_q[free_idx] <= alloc_line_i;
        excl_q[free_idx] <= alloc_excl_i;
        mrg_q[free_idx]  <= 1'b0;
      end
    end
  end

  // R9
  alloc_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (alloc_m == '0));
  // R9
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rsp_m) <= 1);
  // R8
  alloc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
endmodule

// File: rtl/pf_issuer.sv
module pf_issuer
  import pf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int FIFO_DEPTH  = 4,
  parameter int MISS_N      = 4,
  parameter bit INVAL_BASED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_valid_i,
  input  logic [LINE_W-1:0] trig_line_i,
  input  logic [1:0]        trig_kind_i,
  output logic              trig_ready_o,
  output logic              probe_valid_o,
  output logic [LINE_W-1:0] probe_line_o,
  input  logic              probe_hit_i,
  output logic              mem_valid_o,
  output logic [LINE_W-1:0] mem_line_o,
  output logic              mem_excl_o,
  input  logic              mem_ready_i,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  output logic              fill_valid_o,
  output logic [LINE_W-1:0] fill_line_o,
  output logic              fill_excl_o,
  input  logic              dmd_valid_i,
  input  logic [LINE_W-1:0] dmd_line_i,
  output logic              dmd_merge_o,
  output logic              dmd_done_o,
  output logic [LINE_W-1:0] dmd_done_line_o
);
  logic              trig_excl, wanted, dup, push, pop, alloc;
  logic              fifo_empty, fifo_full, fifo_hit, head_excl;
  logic [LINE_W-1:0] head_line;
  logic              tbl_full, tbl_trig_hit, tbl_dmd_hit;
  logic              tbl_rsp_hit, tbl_rsp_excl, tbl_rsp_merged;

  assign trig_excl = (trig_kind_i != ACC_LOAD);
  // exclusive prefetch only makes sense under invalidation coherence
  assign wanted    = INVAL_BASED || !trig_excl;
  assign dup       = fifo_hit || tbl_trig_hit;

  assign trig_ready_o = !fifo_full;
  assign push         = trig_valid_i && !fifo_full && wanted && !dup;

  assign probe_valid_o = !fifo_empty;
  assign probe_line_o  = head_line;
  assign mem_valid_o   = !fifo_empty && !probe_hit_i && !tbl_full;
  assign mem_line_o    = head_line;
  assign mem_excl_o    = head_excl;
  assign alloc         = mem_valid_o && mem_ready_i;
  assign pop           = !fifo_empty && (probe_hit_i || (!tbl_full && mem_ready_i));

  assign fill_valid_o    = rsp_valid_i && tbl_rsp_hit;
  assign fill_line_o     = rsp_line_i;
  assign fill_excl_o     = tbl_rsp_excl;
  assign dmd_merge_o     = tbl_dmd_hit;
  assign dmd_done_o      = fill_valid_o &&
                           (tbl_rsp_merged || (tbl_dmd_hit && (dmd_line_i == rsp_line_i)));
  assign dmd_done_line_o = rsp_line_i;

  pf_fifo #(.LINE_W(LINE_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i(push), .push_line_i(trig_line_i), .push_excl_i(trig_excl),
    .pop_i(pop), .head_line_o(head_line), .head_excl_o(head_excl),
    .empty_o(fifo_empty), .full_o(fifo_full),
    .qry_line_i(trig_line_i), .qry_hit_o(fifo_hit)
  );

  pf_miss_table #(.LINE_W(LINE_W), .ENTRIES(MISS_N)) tbl_i (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .alloc_line_i(head_line), .alloc_excl_i(head_excl),
    .full_o(tbl_full),
    .trig_line_i(trig_line_i), .trig_hit_o(tbl_trig_hit),
    .dmd_valid_i(dmd_valid_i), .dmd_line_i(dmd_line_i), .dmd_hit_o(tbl_dmd_hit),
    .rsp_valid_i(rsp_valid_i), .rsp_line_i(rsp_line_i), .rsp_hit_o(tbl_rsp_hit),
    .rsp_excl_o(tbl_rsp_excl), .rsp_merged_o(tbl_rsp_merged)
  );

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i && !probe_hit_i) |=>
      (mem_valid_o && $stable(mem_line_o) && $stable(mem_excl_o)));
  // R7
  upd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !INVAL_BASED) |-> !mem_excl_o);
  // R5
  done_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmd_done_o |-> fill_valid_o);
endmodule

// File: tb/pf_issuer_tb_top.sv
module pf_issuer_tb_top;
  localparam int LW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          trig_valid_i = 1'b0;
  logic [LW-1:0] trig_line_i = '0;
  logic [1:0]    trig_kind_i = '0;
  logic          mem_ready_i = 1'b1;
  logic          rsp_valid_i = 1'b0;
  logic [LW-1:0] rsp_line_i = '0;
  logic          dmd_valid_i = 1'b0;
  logic [LW-1:0] dmd_line_i = '0;
  logic [63:0]   cache_has = '0;

  logic          trig_ready_o, probe_valid_o, probe_hit_i, mem_valid_o, mem_excl_o;
  logic          fill_valid_o, fill_excl_o, dmd_merge_o, dmd_done_o;
  logic [LW-1:0] probe_line_o, mem_line_o, fill_line_o, dmd_done_line_o;
  logic          u_ready, u_pvalid, u_phit, u_mvalid, u_mexcl;
  logic          u_fvalid, u_fexcl, u_merge, u_done;
  logic [LW-1:0] u_pline, u_mline, u_fline, u_dline;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #10 clk_i = ~clk_i;

  assign probe_hit_i = cache_has[probe_line_o];
  assign u_phit      = cache_has[u_pline];

  pf_issuer #(.LINE_W(LW), .FIFO_DEPTH(4), .MISS_N(2), .INVAL_BASED(1'b1)) dut_i (
    .clk_i, .rst_ni, .trig_valid_i, .trig_line_i, .trig_kind_i, .trig_ready_o,
    .probe_valid_o, .probe_line_o, .probe_hit_i,
    .mem_valid_o, .mem_line_o, .mem_excl_o, .mem_ready_i,
    .rsp_valid_i, .rsp_line_i, .fill_valid_o, .fill_line_o, .fill_excl_o,
    .dmd_valid_i, .dmd_line_i, .dmd_merge_o, .dmd_done_o, .dmd_done_line_o
  );

  pf_issuer #(.LINE_W(LW), .FIFO_DEPTH(4), .MISS_N(2), .INVAL_BASED(1'b0)) dut_upd_i (
    .clk_i, .rst_ni, .trig_valid_i, .trig_line_i, .trig_kind_i, .trig_ready_o(u_ready),
    .probe_valid_o(u_pvalid), .probe_line_o(u_pline), .probe_hit_i(u_phit),
    .mem_valid_o(u_mvalid), .mem_line_o(u_mline), .mem_excl_o(u_mexcl), .mem_ready_i,
    .rsp_valid_i, .rsp_line_i, .fill_valid_o(u_fvalid), .fill_line_o(u_fline),
    .fill_excl_o(u_fexcl), .dmd_valid_i, .dmd_line_i, .dmd_merge_o(u_merge),
    .dmd_done_o(u_done), .dmd_done_line_o(u_dline)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic push(input int ln, input int kind);
    trig_valid_i = 1'b1;
    trig_line_i  = LW'(ln);
    trig_kind_i  = 2'(kind);
    tick();
    trig_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog got=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cache_has[9] = 1'b1;
    cache_has[11] = 1'b1;
    cache_has[13] = 1'b1;
    #35;
    rst_ni = 1'b1;
    tick();

    // R10 reset state
    chk(trig_ready_o == 1'b1, "R10 ready", int'(trig_ready_o), 1);
    chk(probe_valid_o == 1'b0, "R10 probe", int'(probe_valid_o), 0);
    chk(mem_valid_o == 1'b0, "R10 mem", int'(mem_valid_o), 0);
    chk(fill_valid_o == 1'b0 && dmd_merge_o == 1'b0 && dmd_done_o == 1'b0,
        "R10 fill/merge/done", int'({fill_valid_o, dmd_merge_o, dmd_done_o}), 0);

    // sweep kind x cache hit
    for (int k = 0; k < 3; k++) begin
      for (int h = 0; h < 2; h++) begin
        int ln;
        ln = 8 + 2 * k + h;
        push(ln, k);
        #1;
        if (h == 1)
          chk(mem_valid_o == 1'b0, "R2 hit dropped", int'(mem_valid_o), 0);
        else begin
          chk(mem_valid_o && mem_line_o == LW'(ln), "R3 miss issued",
              int'(mem_line_o), ln);
          chk(mem_excl_o == (k != 0), "R1 type", int'(mem_excl_o), int'(k != 0));
        end
        chk(u_pvalid == (k == 0), "R7 update-based filter", int'(u_pvalid), int'(k == 0));
        tick();
        chk(probe_valid_o == 1'b0, "R2 R3 queue drained", int'(probe_valid_o), 0);
        if (h == 0) begin
          rsp_valid_i = 1'b1;
          rsp_line_i  = LW'(ln);
          #1;
          chk(fill_valid_o && fill_line_o == LW'(ln), "R4 fill", int'(fill_valid_o), 1);
          chk(fill_excl_o == (k != 0), "R4 fill type", int'(fill_excl_o), int'(k != 0));
          tick();
          rsp_valid_i = 1'b0;
        end
      end
    end

    // back-pressure and ordering
    mem_ready_i = 1'b0;
    for (int i = 0; i < 4; i++) push(20 + i, 0);
    #1;
    chk(trig_ready_o == 1'b0, "R8 queue full", int'(trig_ready_o), 0);
    chk(mem_valid_o && mem_line_o == LW'(20), "R3 held head", int'(mem_line_o), 20);
    mem_ready_i = 1'b1;
    #1;
    chk(mem_line_o == LW'(20), "R3 order 0", int'(mem_line_o), 20);
    tick();
    chk(mem_valid_o && mem_line_o == LW'(21), "R3 order 1", int'(mem_line_o), 21);
    chk(trig_ready_o == 1'b1, "R8 ready after pop", int'(trig_ready_o), 1);
    tick();
    chk(mem_valid_o == 1'b0, "R8 table full stall", int'(mem_valid_o), 0);
    rsp_valid_i = 1'b1;
    rsp_line_i  = LW'(20);
    #1;
    chk(fill_valid_o && fill_line_o == LW'(20), "R4 fill 20", int'(fill_line_o), 20);
    chk(dmd_done_o == 1'b0, "R5 no demand no done", int'(dmd_done_o), 0);
    tick();
    rsp_valid_i = 1'b0;
    #1;
    chk(mem_valid_o && mem_line_o == LW'(22), "R3 order 2", int'(mem_line_o), 22);
    tick();
    chk(mem_valid_o == 1'b0, "R8 full again", int'(mem_valid_o), 0);

    // merge
    dmd_valid_i = 1'b1;
    dmd_line_i  = LW'(30);
    #1;
    chk(dmd_merge_o == 1'b0, "R5 no merge other line", int'(dmd_merge_o), 0);
    dmd_line_i = LW'(21);
    #1;
    chk(dmd_merge_o == 1'b1, "R5 merge", int'(dmd_merge_o), 1);
    tick();
    dmd_valid_i = 1'b0;
    rsp_valid_i = 1'b1;
    rsp_line_i  = LW'(21);
    #1;
    chk(dmd_done_o && dmd_done_line_o == LW'(21), "R5 done", int'(dmd_done_line_o), 21);
    tick();
    rsp_valid_i = 1'b0;
    #1;
    chk(mem_valid_o && mem_line_o == LW'(23), "R3 order 3", int'(mem_line_o), 23);
    tick();

    // demand and response collide
    dmd_valid_i = 1'b1;
    dmd_line_i  = LW'(22);
    rsp_valid_i = 1'b1;
    rsp_line_i  = LW'(22);
    #1;
    chk(dmd_merge_o && dmd_done_o, "R6 merge+done", int'({dmd_merge_o, dmd_done_o}), 3);
    tick();
    rsp_valid_i = 1'b0;
    #1;
    chk(dmd_merge_o == 1'b0, "R6 line retired", int'(dmd_merge_o), 0);
    dmd_valid_i = 1'b0;
    rsp_valid_i = 1'b1;
    rsp_line_i  = LW'(40);
    #1;
    chk(fill_valid_o == 1'b0, "R4 unknown response", int'(fill_valid_o), 0);
    rsp_line_i = LW'(23);
    #1;
    chk(fill_valid_o && !dmd_done_o, "R4 R5 fill unmerged",
        int'({fill_valid_o, dmd_done_o}), 2);
    tick();
    rsp_valid_i = 1'b0;

    // duplicate suppression
    push(50, 0);
    #1;
    chk(mem_valid_o && mem_line_o == LW'(50), "R9 first issue", int'(mem_line_o), 50);
    push(50, 1);
    #1;
    chk(probe_valid_o == 1'b0, "R9 queued duplicate dropped", int'(probe_valid_o), 0);
    push(50, 2);
    #1;
    chk(probe_valid_o == 1'b0 && mem_valid_o == 1'b0, "R9 in-flight duplicate dropped",
        int'({probe_valid_o, mem_valid_o}), 0);
    rsp_valid_i = 1'b1;
    rsp_line_i  = LW'(50);
    #1;
    chk(fill_valid_o && fill_excl_o == 1'b0, "R9 R1 original type kept",
        int'(fill_excl_o), 0);
    tick();
    rsp_valid_i = 1'b0;

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule